// File: doc/BRIEF.md
# Temperature to ADC Code Converter

This block turns a requested temperature, in millidegrees Celsius, into the code that an ADC thermistor channel would report at that temperature. Threshold logic can then compare live samples against that code.

The conversion has two steps.

1. **Table lookup.** A calibration table of (temperature key, voltage) points is scanned one entry per clock. The voltage is interpolated linearly between the two points that bracket the request, or clamped to an end point when the request lies outside the table.
2. **Scaling.** The voltage in millivolts is scaled into a code. The scale uses a prescale ratio picked by a 2-bit index and a full-scale code constant, and assumes a 1875 mV reference.

A single start pulse launches a conversion. Busy stays high while it runs. A one-cycle done pulse marks the cycle in which the 16-bit code becomes valid. Both divisions share one iterative signed divider on a 64-bit datapath. The calibration table is computed at elaboration from a parameter that selects one of two curves.

Top module: `temp_code_conv`

## Requirements
- R1: The table direction is decided from its first two keys. The table is descending unless key 0 is smaller than key 1, and a single-entry table counts as descending. With TABLE_SEL=0, key(k)=100000−20000·k and volt(k)=400+100·k+20·k², which is descending. With TABLE_SEL=1, key(k)=−40000+20000·k and volt(k)=1800−150·k, which is ascending. Both tables give results that follow R2 to R6.
- R2: The scan starts at index 0 and moves up one entry at a time. In a descending table it stops at the first key below the request. In an ascending table it stops at the first key above the request. A key equal to the request does not stop the scan.
- R3: If the scan stops at index 0, the voltage is volt(0) with no interpolation.
- R4: If the scan passes the last entry, the voltage is volt(N−1).
- R5: If the scan stops at index i between the two ends, the voltage is volt(i−1) + (volt(i)−volt(i−1))·(T−key(i−1)) / (key(i)−key(i−1)). The division truncates toward zero.
- R6: The code is V·num·1000·FS / (den·1875·1000), with signed division truncating toward zero. FS is the full-scale parameter, with default 0x70E4.
- R7: The prescale index psel_i selects num:den as follows: 0 gives 1:1, 1 gives 1:3, 2 gives 10:81, and 3 gives 1:6.
- R8: code_o carries the low 16 bits of the R6 quotient. Higher bits are dropped.
- R9: After reset, busy_o, done_o and code_o are all 0. Busy_o goes high in the cycle after an accepted start. Done_o is high for exactly one cycle, and busy_o falls in that same cycle. Code_o changes only when done_o is high, and otherwise holds its value.
- R10: start_i is ignored while busy_o is high. The temperature and prescale index are captured at the accepted start, so later changes to those inputs do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a conversion when the block is idle |
| temp_i | input | 32 | Requested temperature in millidegrees C, signed |
| psel_i | input | 2 | Prescale ratio index (R7) |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when code_o is new |
| code_o | output | 16 | Resulting ADC code |

## Verification
Each kind of internal fault shows up at code_o in the done cycle of the affected conversion:

- A scan index that is off by one moves the result onto the wrong bracket. Exact-hit and end-of-table requests then return a neighbouring voltage scaled into a visibly different code.
- A sign error in the divider appears as a one-LSB or larger difference on interior points whose slope is negative. The interpolation quotient is then rounded the wrong way.
- Handshake faults appear within a cycle of the done pulse, at busy_o and done_o. A start that is wrongly honoured mid-run produces an extra done pulse or a code taken from the poked inputs.

// File: rtl/t2c_pkg.sv
package t2c_pkg;

  typedef logic signed [63:0] wide_t;

  localparam int     PSEL_W   = 2;
  localparam longint VREF_MV  = 1875;
  localparam longint MILLI    = 1000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_IDIV,
    ST_SDIV
  } st_e;

  // Calibration key (millidegrees) of point k for the chosen curve.
  function automatic wide_t cal_key(input int sel, input int k);
    longint kk;
    kk = longint'(k);
    if (sel == 0) return 100000 - 20000 * kk;
    else          return -40000 + 20000 * kk;
  endfunction

  // Calibration voltage (millivolts) of point k for the chosen curve.
  function automatic wide_t cal_volt(input int sel, input int k);
    longint kk;
    kk = longint'(k);
    if (sel == 0) return 400 + 100 * kk + 20 * kk * kk;
    else          return 1800 - 150 * kk;
  endfunction

  function automatic longint presc_num(input logic [PSEL_W-1:0] idx);
    case (idx)
      2'd2:    return 10;
      default: return 1;
    endcase
  endfunction

  function automatic longint presc_den(input logic [PSEL_W-1:0] idx);
    case (idx)
      2'd0:    return 1;
      2'd1:    return 3;
      2'd2:    return 81;
      default: return 6;
    endcase
  endfunction

  function automatic wide_t interp_numer(input wide_t v_lo, input wide_t v_hi,
                                         input wide_t k_lo, input wide_t t);
    return (v_hi - v_lo) * (t - k_lo);
  endfunction

  function automatic wide_t scale_numer(input wide_t v, input longint num,
                                        input longint fs);
    return v * num * MILLI * fs;
  endfunction

  function automatic wide_t scale_denom(input longint den);
    return den * VREF_MV * MILLI;
  endfunction

endpackage

// File: rtl/t2c_table.sv
module t2c_table
  import t2c_pkg::*;
#(
  parameter int NPTS      = 8,
  parameter int TABLE_SEL = 0
) (
  output wide_t key_o  [NPTS],
  output wide_t volt_o [NPTS],
  output logic  desc_o
);

  generate
    for (genvar g = 0; g < NPTS; g++) begin : g_ent
      assign key_o[g]  = cal_key(TABLE_SEL, g);
      assign volt_o[g] = cal_volt(TABLE_SEL, g);
    end

    if (NPTS > 1) begin : g_dir
      assign desc_o = !(key_o[0] < key_o[1]);
    end else begin : g_one
      assign desc_o = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/t2c_scan.sv
module t2c_scan
  import t2c_pkg::*;
#(
  parameter int NPTS  = 8,
  parameter int IDX_W = $clog2(NPTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  wide_t            target_i,
  input  wide_t            key_i [NPTS],
  input  logic             desc_i,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);

  logic             run_q;
  logic             done_q;
  logic [IDX_W-1:0] idx_q;
  wide_t            cur_key;
  logic             at_end;
  logic             hit;
  logic             stop;

  always_comb begin
    cur_key = '0;
    for (int k = 0; k < NPTS; k++) begin
      if (idx_q == IDX_W'(k)) cur_key = key_i[k];
    end
  end

  assign at_end = (idx_q == IDX_W'(NPTS));
  assign hit    = desc_i ? (cur_key < target_i) : (cur_key > target_i);
  assign stop   = run_q && (at_end || hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= stop;
      if (go_i) begin
        run_q <= 1'b1;
        idx_q <= '0;
      end else if (stop) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign idx_o  = idx_q;

endmodule

// File: rtl/t2c_div.sv
module t2c_div #(
  parameter int W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic signed [W-1:0] num_i,
  input  logic signed [W-1:0] den_i,
  output logic                done_o,
  output logic signed [W-1:0] quo_o
);

  localparam int CNT_W = $clog2(W + 1);

  logic                run_q;
  logic                done_q;
  logic                neg_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [W-1:0]        rem_q;
  logic [W-1:0]        acc_q;
  logic [W-1:0]        dabs_q;
  logic signed [W-1:0] quo_q;

  logic [W-1:0]        num_mag;
  logic [W-1:0]        den_mag;
  logic [W:0]          trial;
  logic                ge;
  logic [W-1:0]        rem_nx;
  logic [W-1:0]        q_nx;
  logic                last_step;

  assign num_mag   = num_i[W-1] ? -num_i : num_i;
  assign den_mag   = den_i[W-1] ? -den_i : den_i;
  assign trial     = {rem_q, acc_q[W-1]};
  assign ge        = (trial >= {1'b0, dabs_q});
  assign rem_nx    = ge ? (trial[W-1:0] - dabs_q) : trial[W-1:0];
  assign q_nx      = {acc_q[W-2:0], ge};
  assign last_step = run_q && (cnt_q == CNT_W'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
      dabs_q <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        rem_q  <= '0;
        acc_q  <= num_mag;
        dabs_q <= den_mag;
        neg_q  <= num_i[W-1] ^ den_i[W-1];
      end else if (run_q) begin
        rem_q <= rem_nx;
        acc_q <= q_nx;
        cnt_q <= cnt_q + 1'b1;
        if (last_step) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          quo_q  <= neg_q ? -$signed(q_nx) : $signed(q_nx);
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

endmodule

// File: rtl/temp_code_conv.sv
module temp_code_conv
  import t2c_pkg::*;
#(
  parameter int     NPTS      = 8,
  parameter int     TABLE_SEL = 0,
  parameter longint FS_CODE   = 64'h70E4,
  parameter int     TEMP_W    = 32,
  parameter int     CODE_W    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic [PSEL_W-1:0]        psel_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [CODE_W-1:0]        code_o
);

  localparam int IDX_W = $clog2(NPTS + 1);

  // Table
  wide_t key_a  [NPTS];
  wide_t volt_a [NPTS];
  logic  desc;

  t2c_table #(.NPTS(NPTS), .TABLE_SEL(TABLE_SEL)) u_table (
    .key_o  (key_a),
    .volt_o (volt_a),
    .desc_o (desc)
  );

  // Control state and named internal events
  st_e               st_q;
  wide_t             temp_q;
  logic [PSEL_W-1:0] psel_q;
  wide_t             base_q;
  logic              busy_q;
  logic              done_q;
  logic [CODE_W-1:0] code_q;

  logic              accept;
  logic              scan_done;
  logic [IDX_W-1:0]  scan_idx;
  logic              div_go;
  logic              div_done;
  wide_t             div_num;
  wide_t             div_den;
  wide_t             div_quo;

  assign accept = (st_q == ST_IDLE) && start_i;

  t2c_scan #(.NPTS(NPTS), .IDX_W(IDX_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (accept),
    .target_i (temp_q),
    .key_i    (key_a),
    .desc_i   (desc),
    .done_o   (scan_done),
    .idx_o    (scan_idx)
  );

  t2c_div #(.W(64)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (div_go),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  // Bracketing points around the scan stop index
  wide_t lo_key, lo_volt, hi_key, hi_volt, clamp_volt;
  logic  edge_lo, edge_hi;

  always_comb begin
    lo_key  = '0;
    lo_volt = '0;
    hi_key  = '0;
    hi_volt = '0;
    for (int k = 0; k < NPTS; k++) begin
      if (scan_idx == IDX_W'(k)) begin
        hi_key  = key_a[k];
        hi_volt = volt_a[k];
      end
      if (scan_idx == IDX_W'(k + 1)) begin
        lo_key  = key_a[k];
        lo_volt = volt_a[k];
      end
    end
  end

  assign edge_lo    = (scan_idx == '0);
  assign edge_hi    = (scan_idx == IDX_W'(NPTS));
  assign clamp_volt = edge_lo ? volt_a[0] : volt_a[NPTS-1];

  // Divider operand selection
  always_comb begin
    div_go  = 1'b0;
    div_num = '0;
    div_den = 64'sd1;
    case (st_q)
      ST_SCAN: begin
        if (scan_done) begin
          div_go = 1'b1;
          if (edge_lo || edge_hi) begin
            div_num = scale_numer(clamp_volt, presc_num(psel_q), FS_CODE);
            div_den = scale_denom(presc_den(psel_q));
          end else begin
            div_num = interp_numer(lo_volt, hi_volt, lo_key, temp_q);
            div_den = hi_key - lo_key;
          end
        end
      end
      ST_IDIV: begin
        if (div_done) begin
          div_go  = 1'b1;
          div_num = scale_numer(base_q + div_quo, presc_num(psel_q), FS_CODE);
          div_den = scale_denom(presc_den(psel_q));
        end
      end
      default: ;
    endcase
  end

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      temp_q <= '0;
      psel_q <= '0;
      base_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      code_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            temp_q <= wide_t'(temp_i);
            psel_q <= psel_i;
            busy_q <= 1'b1;
            st_q   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (scan_done) begin
            if (edge_lo || edge_hi) begin
              st_q <= ST_SDIV;
            end else begin
              base_q <= lo_volt;
              st_q   <= ST_IDIV;
            end
          end
        end
        ST_IDIV: begin
          if (div_done) st_q <= ST_SDIV;
        end
        ST_SDIV: begin
          if (div_done) begin
            code_q <= div_quo[CODE_W-1:0];
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign code_o = code_q;

endmodule

// File: rtl/t2c_checker.sv
module t2c_checker
  import t2c_pkg::*;
#(
  parameter int NPTS   = 8,
  parameter int IDX_W  = 4,
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] code_o,
  input wide_t             temp_q,
  input logic [IDX_W-1:0]  scan_idx,
  input logic              scan_done,
  input logic              div_go
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                          // R9

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);                                    // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);                                          // R9

  AST_CODE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> done_o);                                 // R9

  AST_TEMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(temp_q));               // R10

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(scan_idx) <= NPTS);                                      // R2

  AST_SCAN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> busy_o);                                        // R2

  AST_DIV_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> busy_o);                                           // R10

endmodule

bind temp_code_conv t2c_checker #(
  .NPTS   (NPTS),
  .IDX_W  (IDX_W),
  .CODE_W (CODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .code_o    (code_o),
  .temp_q    (temp_q),
  .scan_idx  (scan_idx),
  .scan_done (scan_done),
  .div_go    (div_go)
);

// File: tb/temp_code_conv_tb.sv
`timescale 1ns/1ps
module temp_code_conv_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic               s0 = 1'b0, s1 = 1'b0;
  logic signed [31:0] t0 = '0, t1 = '0;
  logic [1:0]         p0 = '0, p1 = '0;
  logic               b0, b1, d0, d1;
  logic [15:0]        c0, c1;

  temp_code_conv u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(s0), .temp_i(t0), .psel_i(p0),
    .busy_o(b0), .done_o(d0), .code_o(c0)
  );

  temp_code_conv #(.TABLE_SEL(1), .FS_CODE(64'd90000)) u_dut_asc (
    .clk(clk), .rst_n(rst_n), .start_i(s1), .temp_i(t1), .psel_i(p1),
    .busy_o(b1), .done_o(d1), .code_o(c1)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_push0 = 0, n_push1 = 0, n_done0 = 0, n_done1 = 0;
  longint eq0[$], eq1[$];
  string  tq0[$], tq1[$];
  logic   pd0 = 1'b0, pd1 = 1'b0;

  task automatic chk(input string rq, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", rq, got, exp);
    end
  endtask

  // Reference model, written from the requirements
  function automatic longint m_key(input int sel, input int k);
    if (sel == 0) return 100000 - 20000 * longint'(k);
    return 20000 * longint'(k) - 40000;
  endfunction

  function automatic longint m_volt(input int sel, input int k);
    longint kk = longint'(k);
    if (sel == 0) return 400 + kk * (100 + 20 * kk);
    return 1800 - 150 * kk;
  endfunction

  function automatic longint m_code(input int sel, input longint t, input int ps,
                                    input longint fs);
    int     n = 8;
    bit     desc = !(m_key(sel, 0) < m_key(sel, 1));
    int     i = 0;
    longint v, num, den, r;
    while (i < n) begin
      if (desc && m_key(sel, i) < t) break;
      if (!desc && m_key(sel, i) > t) break;
      i++;
    end
    if (i == 0)      v = m_volt(sel, 0);
    else if (i == n) v = m_volt(sel, n - 1);
    else v = m_volt(sel, i - 1) + ((m_volt(sel, i) - m_volt(sel, i - 1)) *
             (t - m_key(sel, i - 1))) / (m_key(sel, i) - m_key(sel, i - 1));
    num = (ps == 2) ? 10 : 1;
    den = (ps == 0) ? 1 : (ps == 1) ? 3 : (ps == 2) ? 81 : 6;
    r = (v * num * 1000 * fs) / (den * 1875 * 1000);
    return r & 64'hFFFF;
  endfunction

  // Driver: pushes expected code, launches, optionally pokes start mid-run (R10)
  task automatic go(input int sel, input longint t, input int ps, input string tag,
                    input bit poke);
    longint e = m_code(sel, t, ps, (sel == 0) ? 64'd28900 : 64'd90000);
    @(negedge clk);
    if (sel == 0) begin
      eq0.push_back(e); tq0.push_back(tag); n_push0++;
      s0 = 1'b1; t0 = 32'(t); p0 = 2'(ps);
    end else begin
      eq1.push_back(e); tq1.push_back(tag); n_push1++;
      s1 = 1'b1; t1 = 32'(t); p1 = 2'(ps);
    end
    @(negedge clk);
    s0 = 1'b0; s1 = 1'b0;
    chk("R9 busy after start", (sel == 0) ? b0 : b1, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk("R10 busy at poke", (sel == 0) ? b0 : b1, 1);
      if (sel == 0) begin s0 = 1'b1; t0 = -32'sd90000; p0 = 2'd3; end
      else          begin s1 = 1'b1; t1 = -32'sd90000; p1 = 2'd3; end
      @(negedge clk);
      s0 = 1'b0; s1 = 1'b0;
    end
    while (((sel == 0) ? eq0.size() : eq1.size()) != 0) @(negedge clk);
    if (poke) begin
      repeat (200) @(negedge clk);
      chk("R10 code unchanged after ignored start", (sel == 0) ? c0 : c1, e);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (d0) begin
        n_done0++;
        chk("R9 busy low with done", b0, 0);
        if (eq0.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R10: unexpected done on u_dut, got 1 expected 0");
        end else chk(tq0.pop_front(), c0, eq0.pop_front());
      end
      if (d1) begin
        n_done1++;
        chk("R9 busy low with done", b1, 0);
        if (eq1.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R10: unexpected done on u_dut_asc, got 1 expected 0");
        end else chk(tq1.pop_front(), c1, eq1.pop_front());
      end
      if (pd0 && d0) chk("R9 done width", 2, 1);
      if (pd1 && d1) chk("R9 done width", 2, 1);
      pd0 = d0;
      pd1 = d1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9: watchdog expired, got busy expected idle");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R9 reset busy", b0, 0);
    chk("R9 reset done", d0, 0);
    chk("R9 reset code", c0, 0);
    chk("R9 reset code asc", c1, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Descending table
    go(0, 55000, 0, "R5 interior", 0);
    go(0, 55001, 0, "R5 truncation", 0);
    go(0, 60000, 0, "R2 exact interior key", 0);
    go(0, 100000, 0, "R2 exact first key", 0);
    go(0, 150000, 0, "R3 clamp low index", 0);
    go(0, -40000, 0, "R4 exact last key", 0);
    go(0, -90000, 0, "R4 past end", 0);
    go(0, -2000000000, 0, "R4 far past end", 0);
    go(0, 30000, 0, "R6 scale 1:1", 0);
    for (int ps = 1; ps < 4; ps++) go(0, 12345, ps, "R7 prescale", 0);

    // Ascending table, larger full-scale
    go(1, -39999, 0, "R5 negative slope truncation", 0);
    go(1, 70000, 0, "R1 ascending interior", 0);
    go(1, -50000, 0, "R3 clamp low ascending", 0);
    go(1, 200000, 0, "R4 past end ascending", 0);
    go(1, 100000, 0, "R2 exact key ascending", 0);
    go(1, -40000, 0, "R8 code truncated to 16 bits", 0);
    go(1, 5000, 2, "R7 prescale 10:81", 0);

    // Start ignored while busy
    go(0, 55000, 0, "R10 poked run", 1);
    go(1, 15000, 1, "R10 poked run asc", 1);

    repeat (20) @(negedge clk);
    chk("R10 done count u_dut", n_done0, n_push0);
    chk("R10 done count u_dut_asc", n_done1, n_push1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule